// File: doc/BRIEF.md
# Branch and Flag Control Unit

This block owns the program counter and the two condition flags of a small processor that fetches 16-bit instruction words. For each valid instruction it works out the address of the next instruction. That address is either the following word or the target of an absolute jump, a relative jump, a call or a return. The block keeps the zero (Z) and carry (C) flags current from subtract, compare and multiply results. Each address it produces is checked against the length of the loaded program, and an address outside that range causes a fatal fault.

Instruction decode sits outside this block. Decode presents one instruction per cycle as a kind code, a condition selector, a relative/absolute select, the two operand values, the immediate targets, and the current link-register value. The block returns three things:

- the PC register;
- a one-cycle write strobe and data for the link register (register 14) on a call;
- sticky fault and halt indications. Once either of these is set, the machine is frozen until reset.

The PC is incremented before the instruction acts. Relative offsets and saved return addresses are therefore measured from the word after the current one.

Top module: `brFlagUnit`

## Requirements
- R1: After reset, pc is 0, flagZ and flagC are 0, fault and halted are 0, and linkWe is 0.
- R2: A valid instruction of kind 0 (plain sequential) or kind 7 (spare) moves pc to pc+1 on the next clock edge and leaves both flags unchanged.
- R3: Kind 1 (subtract/compare) sets flagZ to (opA == opB) and flagC to NOT(opA < opB), comparing the operands as unsigned numbers. pc moves to pc+1.
- R4: Kind 2 (multiply) sets flagZ when opA or opB is zero and clears it otherwise. flagC is unchanged and pc moves to pc+1.
- R5: Kind 3 (jump) with relMode=0 loads pc with absTarget when its condition holds. The condSel codes are: 0 always, 1 Z set, 2 Z clear, 3 C set, 4 C clear. Codes 5 to 7 never hold.
- R6: Kind 3 with relMode=1 and a true condition loads pc with pc+1 plus relOffset, where relOffset is read as a signed 8-bit value.
- R7: A jump whose condition is false loads pc+1. Its targets play no part, and only the sequential range check applies.
- R8: Kind 4 (call) ignores condSel. It loads pc with absTarget (relMode=0) or with pc+1+relOffset (relMode=1). In the same cycle, before the clock edge, it drives linkWe=1 with linkData=pc+1.
- R9: Kind 5 (return) loads pc with linkIn.
- R10: If the address chosen for any executed instruction is negative or not less than progLen, fault is set. In that case pc and the flags keep their values and linkWe stays 0.
- R11: Kind 6 (stop) sets halted, and pc keeps its value.
- R12: Once fault or halted is set, both stay set until reset. No later instruction changes pc or the flags, and no later instruction raises linkWe.
- R13: In a cycle with instValid=0, pc, the flags, fault and halted all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | An instruction is presented this cycle |
| opKind | input | 3 | Instruction kind (encoding in R2 to R11) |
| condSel | input | 3 | Jump condition selector |
| relMode | input | 1 | 1 selects a relative target, 0 an absolute target |
| opA | input | DATA_W | First operand (subtract/compare/multiply) |
| opB | input | DATA_W | Second operand |
| absTarget | input | PC_W | Absolute target address |
| relOffset | input | OFF_W | Signed relative offset |
| linkIn | input | PC_W | Current link-register value, used by return |
| progLen | input | PC_W+1 | Program length in words |
| pc | output | PC_W | Program counter (address of the current instruction) |
| linkWe | output | 1 | Link-register write strobe |
| linkData | output | PC_W | Return address written on a call |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag (set when not less-than) |
| fault | output | 1 | Sticky range fault |
| halted | output | 1 | Sticky stop indication |

## Verification
The assertions check the following on every cycle:

- fault and halted stay set once set;
- pc and the flags stay frozen once either indication is up;
- an idle cycle changes no state;
- a link write never happens while the machine is stopped;
- decode never selects more than one target source.

The exact flag values, the signed relative arithmetic, the outcome of each condition code, and where the range boundary falls relative to progLen can only be shown by the bench's scenarios. The bench compares each of these against a model of its own, under random instruction streams and directed edge cases.

// File: rtl/brPkg.sv
package brPkg;

  typedef enum logic [2:0] {
    KIND_SEQ    = 3'd0,
    KIND_SUBCMP = 3'd1,
    KIND_MUL    = 3'd2,
    KIND_JUMP   = 3'd3,
    KIND_CALL   = 3'd4,
    KIND_RET    = 3'd5,
    KIND_STOP   = 3'd6,
    KIND_SPARE  = 3'd7
  } opKindT;

  localparam logic [2:0] COND_ALWAYS = 3'd0;
  localparam logic [2:0] COND_ZSET   = 3'd1;
  localparam logic [2:0] COND_ZCLR   = 3'd2;
  localparam logic [2:0] COND_CSET   = 3'd3;
  localparam logic [2:0] COND_CCLR   = 3'd4;

  // strobes handed from control to datapath
  typedef struct packed {
    logic exec;      // instruction acts this cycle
    logic updSub;    // Z/C from subtract/compare
    logic updMul;    // Z from multiply
    logic takeAbs;   // target = absolute immediate
    logic takeRel;   // target = next + offset
    logic takeLink;  // target = link register
    logic callLink;  // write return address
    logic stop;      // halt request
  } ctrlStrobeT;

endpackage

// File: rtl/brCtrl.sv
module brCtrl
  import brPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instValid,
  input  logic [2:0] opKind,
  input  logic [2:0] condSel,
  input  logic       relMode,
  input  logic       flagZ,
  input  logic       flagC,
  input  logic       fault,
  input  logic       halted,
  output ctrlStrobeT strb
);

  logic condOk;

  always_comb begin
    unique case (condSel)
      COND_ALWAYS: condOk = 1'b1;
      COND_ZSET:   condOk = flagZ;
      COND_ZCLR:   condOk = !flagZ;
      COND_CSET:   condOk = flagC;
      COND_CCLR:   condOk = !flagC;
      default:     condOk = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    strb.exec = instValid && !fault && !halted;
    unique case (opKindT'(opKind))
      KIND_SUBCMP: strb.updSub = 1'b1;
      KIND_MUL:    strb.updMul = 1'b1;
      KIND_JUMP: begin
        strb.takeAbs = condOk && !relMode;
        strb.takeRel = condOk && relMode;
      end
      KIND_CALL: begin
        strb.takeAbs  = !relMode;
        strb.takeRel  = relMode;
        strb.callLink = 1'b1;
      end
      KIND_RET:  strb.takeLink = 1'b1;
      KIND_STOP: strb.stop = 1'b1;
      default: ;
    endcase
  end

  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeAbs, strb.takeRel, strb.takeLink}));

endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [PC_W-1:0]   absTarget,
  input  logic [OFF_W-1:0]  relOffset,
  input  logic [PC_W-1:0]   linkIn,
  input  logic [PC_W:0]     progLen,
  output logic [PC_W-1:0]   pc,
  output logic              linkWe,
  output logic [PC_W-1:0]   linkData,
  output logic              flagZ,
  output logic              flagC,
  output logic              fault,
  output logic              halted
);

  localparam int EXT_W = PC_W + 2;

  logic signed [EXT_W-1:0] seqPc, offExt, relSum, target, lenExt;
  logic outOfRange;

  always_comb begin
    seqPc  = $signed({2'b00, pc}) + EXT_W'(1);
    offExt = $signed({{(EXT_W-OFF_W){relOffset[OFF_W-1]}}, relOffset});
    relSum = seqPc + offExt;
    lenExt = $signed({1'b0, progLen});
    if (strb.takeAbs)       target = $signed({2'b00, absTarget});
    else if (strb.takeRel)  target = relSum;
    else if (strb.takeLink) target = $signed({2'b00, linkIn});
    else                    target = seqPc;
    outOfRange = target[EXT_W-1] || (target >= lenExt);
  end

  assign linkWe   = strb.exec && strb.callLink && !outOfRange;
  assign linkData = seqPc[PC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc     <= '0;
      flagZ  <= 1'b0;
      flagC  <= 1'b0;
      fault  <= 1'b0;
      halted <= 1'b0;
    end else if (strb.exec) begin
      if (strb.stop) begin
        halted <= 1'b1;
      end else if (outOfRange) begin
        fault <= 1'b1;
      end else begin
        pc <= target[PC_W-1:0];
        if (strb.updSub) begin
          flagZ <= (opA == opB);
          flagC <= !(opA < opB);
        end else if (strb.updMul) begin
          flagZ <= (opA == '0) || (opB == '0);
        end
      end
    end
  end

  // R12
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R12
  frozen_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fault || halted) |=> ($stable(pc) && $stable(flagZ) && $stable(flagC)));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.exec |=> ($stable(pc) && $stable(flagZ) && $stable(flagC)
                    && $stable(fault) && $stable(halted)));

  // R8
  link_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> (!fault && !halted));

endmodule

// File: rtl/brFlagUnit.sv
module brFlagUnit
  import brPkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        opKind,
  input  logic [2:0]        condSel,
  input  logic              relMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [PC_W-1:0]   absTarget,
  input  logic [OFF_W-1:0]  relOffset,
  input  logic [PC_W-1:0]   linkIn,
  input  logic [PC_W:0]     progLen,
  output logic [PC_W-1:0]   pc,
  output logic              linkWe,
  output logic [PC_W-1:0]   linkData,
  output logic              flagZ,
  output logic              flagC,
  output logic              fault,
  output logic              halted
);

  ctrlStrobeT strb;

  brCtrl ctrlInst (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opKind(opKind),
    .condSel(condSel), .relMode(relMode), .flagZ(flagZ), .flagC(flagC),
    .fault(fault), .halted(halted), .strb(strb)
  );

  brDatapath #(.PC_W(PC_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) dpInst (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .absTarget(absTarget), .relOffset(relOffset), .linkIn(linkIn),
    .progLen(progLen), .pc(pc), .linkWe(linkWe), .linkData(linkData),
    .flagZ(flagZ), .flagC(flagC), .fault(fault), .halted(halted)
  );

endmodule

// File: tb/brFlagUnit_test.sv
`timescale 1ns/1ps
module brFlagUnit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [2:0]  opKind = '0, condSel = '0;
  logic        relMode = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] absTarget = '0, linkIn = '0;
  logic [7:0]  relOffset = '0;
  logic [16:0] progLen = 17'd20;
  logic [15:0] pc, linkData;
  logic        linkWe, flagZ, flagC, fault, halted;

  int testCnt = 0, failCnt = 0;
  int ePc;
  bit eZ, eC, eFault, eHalt;

  brFlagUnit uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opKind(opKind),
    .condSel(condSel), .relMode(relMode), .opA(opA), .opB(opB),
    .absTarget(absTarget), .relOffset(relOffset), .linkIn(linkIn),
    .progLen(progLen), .pc(pc), .linkWe(linkWe), .linkData(linkData),
    .flagZ(flagZ), .flagC(flagC), .fault(fault), .halted(halted)
  );

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit condHolds(int c, bit z, bit cf);
    case (c)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return cf;
      4: return !cf;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int nextAddr(int k, int c, bit r, int absT, int off, int lnk);
    int seq = ePc + 1;
    case (k)
      3: if (condHolds(c, eZ, eC)) return r ? seq + off : absT;
      4: return r ? seq + off : absT;
      5: return lnk;
      default: ;
    endcase
    return seq;
  endfunction

  task automatic checkState(string tag);
    chk(pc == ePc[15:0], tag, "pc", pc, ePc);
    chk(flagZ == eZ && flagC == eC, tag, "flags ZC", {flagZ, flagC}, {eZ, eC});
    chk(fault == eFault && halted == eHalt, tag, "fault/halt", {fault, halted}, {eFault, eHalt});
  endtask

  task automatic step(bit v, int k, int c, bit r, int a, int b,
                      int absT, int off, int lnk, string tag);
    int tgt;
    bit bad, expWe;
    @(negedge clk);
    instValid = v; opKind = k[2:0]; condSel = c[2:0]; relMode = r;
    opA = a; opB = b; absTarget = absT[15:0]; relOffset = off[7:0]; linkIn = lnk[15:0];
    expWe = 1'b0;
    tgt = nextAddr(k, c, r, absT, off, lnk);
    bad = (tgt < 0) || (tgt >= int'(progLen));
    if (v && !eFault && !eHalt) begin
      if (k == 6) eHalt = 1'b1;
      else if (bad) eFault = 1'b1;
      else begin
        if (k == 4) expWe = 1'b1;
        if (k == 1) begin eZ = (a == b); eC = !(unsigned'(a) < unsigned'(b)); end
        if (k == 2) eZ = (a == 0) || (b == 0);
        ePc = tgt;
      end
    end
    #1;
    chk(linkWe == expWe, tag, "linkWe", linkWe, expWe);
    if (expWe) chk(int'(linkData) == int'(pc) + 1, tag, "linkData", linkData, int'(pc) + 1);
    @(posedge clk);
    #1;
    checkState(tag);
  endtask

  task automatic doReset(int len);
    @(negedge clk);
    rstN = 1'b0; instValid = 1'b0; progLen = len[16:0];
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    ePc = 0; eZ = 0; eC = 0; eFault = 0; eHalt = 0;
    #1;
    checkState("R1 reset");
    chk(linkWe == 1'b0, "R1", "linkWe", linkWe, 0);
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    doReset(20);

    // directed flag cases
    step(1, 1, 0, 0, 5, 5, 0, 0, 0, "R3 equal");
    step(1, 1, 0, 0, 3, 7, 0, 0, 0, "R3 less");
    step(1, 1, 0, 0, 9, 2, 0, 0, 0, "R3 greater");
    step(1, 2, 0, 0, 0, 7, 0, 0, 0, "R4 zero factor keeps C");
    step(1, 2, 0, 0, 3, 4, 0, 0, 0, "R4 nonzero");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 seq");
    step(1, 7, 0, 0, 0, 0, 0, 0, 0, "R2 spare");
    step(0, 3, 0, 0, 0, 0, 15, 0, 0, "R13 idle");
    // flags now Z=0 C=1
    step(1, 3, 2, 0, 0, 0, 15, 0, 0, "R5 abs Z clear taken");
    step(1, 3, 1, 0, 0, 0, 2, 0, 0, "R7 Z set not taken");
    step(1, 3, 5, 0, 0, 0, 2, 0, 0, "R7 reserved cond");
    step(1, 3, 3, 1, 0, 0, 0, -10, 0, "R6 rel back");
    step(1, 3, 4, 1, 0, 0, 0, 3, 0, "R7 C clear not taken");
    step(1, 4, 1, 0, 0, 0, 3, 0, 0, "R8 call abs");
    step(1, 4, 0, 1, 0, 0, 0, 2, 0, "R8 call rel");
    step(1, 5, 0, 0, 0, 0, 0, 0, 10, "R9 return");
    step(1, 3, 0, 1, 0, 0, 0, -128, 0, "R10 negative target");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R12 after fault");
    step(1, 1, 0, 0, 4, 4, 0, 0, 0, "R12 flags frozen");

    doReset(20);
    step(1, 3, 0, 0, 0, 0, 20, 0, 0, "R10 abs equals length");
    step(1, 4, 0, 0, 0, 0, 3, 0, 0, "R12 no call after fault");

    doReset(20);
    step(1, 3, 0, 0, 0, 0, 19, 0, 0, "R5 last word");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 sequential off end");

    doReset(20);
    step(1, 4, 0, 0, 0, 0, 18, 0, 0, "R8 call near end");
    step(1, 4, 0, 0, 0, 0, 25, 0, 0, "R10 call out of range");

    doReset(20);
    step(1, 5, 0, 0, 0, 0, 0, 0, 25, "R10 return out of range");

    doReset(20);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 seq");
    step(1, 6, 0, 0, 0, 0, 0, 0, 0, "R11 stop");
    step(1, 3, 0, 0, 0, 0, 5, 0, 0, "R12 halted jump");
    step(1, 2, 0, 0, 0, 0, 0, 0, 0, "R12 halted mul");

    // constrained random stream
    doReset(200);
    for (int i = 0; i < 400; i++) begin
      int k, c, a, b, absT, off, lnk, tgt;
      bit r, v;
      v = ($urandom % 8) != 0;
      k = $urandom % 8;
      if (k == 6) k = 0;
      c = $urandom % 8;
      r = $urandom % 2;
      if ($urandom % 2) begin a = $urandom % 4; b = $urandom % 4; end
      else begin a = $urandom; b = $urandom; end
      absT = $urandom % 200;
      off = int'($signed(8'($urandom)));
      lnk = $urandom % 200;
      tgt = nextAddr(k, c, r, absT, off, lnk);
      if (tgt < 0 || tgt >= 200) begin k = 3; c = 0; r = 0; absT = 0; end
      step(v, k, c, r, a, b, absT, off, lnk, "R2-random R5 R6 R8");
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule